// File: doc/BRIEF.md
# Tile Network Packetizer

This block sits between a tile client and a packet network laid out as a 4x4 folded torus. The client presents one request at a time. A request holds a destination coordinate, a virtual channel number, a logarithmic payload size code and a count of payload words. Once the request is accepted, the block builds a relative source route from its own tile position, which is fixed by parameters, to the destination. It then drives a head flit, followed by one flit per payload word; the last of these flits is marked as the tail.

Each flit carries a type, a size code, a one-hot virtual channel field, a route field and a data word. The network returns one ready bit per virtual channel. A flit moves only in a cycle where the ready bit of its own channel is high. The block pulls payload words from the client one at a time, as each payload flit is loaded. Requests with an invalid size code or a zero word count are dropped, and an error pulse reports the drop.

Top module: `tile_ni_pkt`

## Requirements
- R1: With no packet in progress, the flit type is idle (00), the vc, size, route and data fields are all zero, and `req_ready_o` is high.
- R2: When a valid request is accepted, the flit type is head (01) in the next cycle, with data zero. After the head come word-count minus one body flits (10) and then one tail flit (11). Payload flit k carries payload word k, and the tail carries the last word. A one-word request therefore produces a head flit and then a tail flit.
- R3: A flit is transferred only on a clock edge where `vc_ready_i[vc]` is high. While that bit is low, all flit outputs are held unchanged.
- R4: On every non-idle flit, the vc field is one-hot, with bit `vc` set.
- R5: Every flit of a packet carries the request's size code (0 means 1 bit, 8 means 256 bits).
- R6: Ring positions along both rows and columns follow the physical order 0,2,3,1. On each leg the route takes the shorter ring direction. A tie of two steps goes in the positive direction, which is increasing ring position.
- R7: The route holds one 2-bit code per hop, with hop 0 in bits [1:0]. The codes are 00 straight, 01 left, 10 right and 11 extract. The row leg is made of straight hops. The first column hop after a row leg is a turn: left when both legs have the same sign, right otherwise. The other column hops are straight. The next hop is extract, and every remaining hop is also extract.
- R8: A request with a size code above 8 or a word count of 0 is accepted and then dropped. In that case `err_o` is high for exactly one cycle, the cycle after acceptance, and no flit is sent.
- R9: `pay_take_o` is high in the cycle where a payload flit is loaded. The `pay_data_i` of that cycle appears on `flit_data_o` in the next cycle.
- R10: `req_ready_o` is low while a packet is in progress. It goes high again in the cycle after the tail flit is transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block can take a request |
| req_dst_x_i | input | 2 | Destination column index |
| req_dst_y_i | input | 2 | Destination row index |
| req_vc_i | input | $clog2(NUM_VC) | Virtual channel number |
| req_size_i | input | 4 | Logarithmic payload size code |
| req_len_i | input | LEN_W | Payload word count |
| pay_data_i | input | DATA_W | Current payload word from client |
| pay_take_o | output | 1 | Payload word consumed this cycle |
| err_o | output | 1 | Rejected-request pulse |
| vc_ready_i | input | NUM_VC | Per-channel ready from network |
| flit_type_o | output | 2 | Flit type |
| flit_size_o | output | 4 | Size code |
| flit_vc_o | output | NUM_VC | One-hot virtual channel |
| flit_route_o | output | 16 | Source route |
| flit_data_o | output | DATA_W | Flit data |

## Verification
The bench places the tile at column 1, row 2 rather than the default corner. From there every ring distance of 0 to 3 occurs on both axes: the two-step tie, a one-step negative leg, and both left and right turns. The bench uses a 16-bit data word and a 3-bit word count, so packets of one to seven payload flits stay short and many can be run. The ready vector is drawn at random on every cycle, which exercises long stalls and back-to-back transfers on each of the eight channels.

// File: rtl/tile_ni_pkg.sv
package tile_ni_pkg;
  typedef enum logic [1:0] {
    FT_IDLE = 2'b00,
    FT_HEAD = 2'b01,
    FT_BODY = 2'b10,
    FT_TAIL = 2'b11
  } flit_type_e;

  localparam logic [1:0] HOP_STRAIGHT = 2'b00;
  localparam logic [1:0] HOP_LEFT     = 2'b01;
  localparam logic [1:0] HOP_RIGHT    = 2'b10;
  localparam logic [1:0] HOP_EXTRACT  = 2'b11;

  localparam logic [3:0] SIZE_MAX = 4'd8;

  // position of a node index on the physical ring 0,2,3,1
  function automatic logic [1:0] ring_pos(input logic [1:0] idx);
    case (idx)
      2'd0:    ring_pos = 2'd0;
      2'd2:    ring_pos = 2'd1;
      2'd3:    ring_pos = 2'd2;
      default: ring_pos = 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/ni_route_gen.sv
module ni_route_gen
  import tile_ni_pkg::*;
#(
  parameter int MY_X = 0,
  parameter int MY_Y = 0,
  parameter int HOPS = 8
) (
  input  logic [1:0]        dst_x_i,
  input  logic [1:0]        dst_y_i,
  output logic [2*HOPS-1:0] route_o
);
  localparam logic [1:0] SRC_X = 2'(MY_X);
  localparam logic [1:0] SRC_Y = 2'(MY_Y);

  logic [1:0] dx, dy, nx, ny, turn;
  logic       negx, negy;

  always_comb begin
    dx   = ring_pos(dst_x_i) - ring_pos(SRC_X);
    dy   = ring_pos(dst_y_i) - ring_pos(SRC_Y);
    negx = (dx == 2'd3);
    negy = (dy == 2'd3);
    nx   = negx ? 2'd1 : dx;
    ny   = negy ? 2'd1 : dy;
    turn = (negx == negy) ? HOP_LEFT : HOP_RIGHT;
    route_o = '0;
    for (int i = 0; i < HOPS; i++) begin
      if (i < int'(nx))
        route_o[2*i +: 2] = HOP_STRAIGHT;
      else if (i < int'(nx) + int'(ny))
        route_o[2*i +: 2] = (i == int'(nx) && nx != 2'd0) ? turn : HOP_STRAIGHT;
      else
        route_o[2*i +: 2] = HOP_EXTRACT;
    end
  end
endmodule

// File: rtl/ni_vc_onehot.sv
module ni_vc_onehot #(
  parameter int NUM_VC = 8,
  localparam int VC_W  = $clog2(NUM_VC)
) (
  input  logic              en_i,
  input  logic [VC_W-1:0]   vc_i,
  output logic [NUM_VC-1:0] oh_o
);
  for (genvar g = 0; g < NUM_VC; g++) begin : g_bit
    assign oh_o[g] = en_i && (vc_i == VC_W'(g));
  end
endmodule

// File: rtl/ni_flit_seq.sv
module ni_flit_seq
  import tile_ni_pkg::*;
#(
  parameter int NUM_VC  = 8,
  parameter int DATA_W  = 32,
  parameter int LEN_W   = 4,
  parameter int ROUTE_W = 16,
  localparam int VC_W   = $clog2(NUM_VC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [3:0]         size_i,
  input  logic [ROUTE_W-1:0] route_i,
  input  logic [VC_W-1:0]    vc_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [DATA_W-1:0]  pay_data_i,
  input  logic [NUM_VC-1:0]  vc_ready_i,
  output flit_type_e         type_o,
  output logic [3:0]         size_o,
  output logic [ROUTE_W-1:0] route_o,
  output logic [VC_W-1:0]    vc_o,
  output logic [DATA_W-1:0]  data_o,
  output logic               pay_take_o
);
  flit_type_e         type_q;
  logic [3:0]         size_q;
  logic [ROUTE_W-1:0] route_q;
  logic [VC_W-1:0]    vc_q;
  logic [DATA_W-1:0]  data_q;
  logic [LEN_W-1:0]   left_q;
  logic               go;

  assign go         = (type_q != FT_IDLE) && vc_ready_i[vc_q];
  assign pay_take_o = go && (left_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      type_q  <= FT_IDLE;
      size_q  <= '0;
      route_q <= '0;
      vc_q    <= '0;
      data_q  <= '0;
      left_q  <= '0;
    end else if (start_i) begin
      type_q  <= FT_HEAD;
      size_q  <= size_i;
      route_q <= route_i;
      vc_q    <= vc_i;
      data_q  <= '0;
      left_q  <= len_i;
    end else if (go) begin
      if (left_q != '0) begin
        type_q <= (left_q == LEN_W'(1)) ? FT_TAIL : FT_BODY;
        data_q <= pay_data_i;
        left_q <= left_q - LEN_W'(1);
      end else begin
        type_q  <= FT_IDLE;
        size_q  <= '0;
        route_q <= '0;
        vc_q    <= '0;
        data_q  <= '0;
      end
    end
  end

  assign type_o  = type_q;
  assign size_o  = size_q;
  assign route_o = route_q;
  assign vc_o    = vc_q;
  assign data_o  = data_q;

  a_r3_hold_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (type_q != FT_IDLE && !vc_ready_i[vc_q]) |=>
      ($stable(type_q) && $stable(data_q) && $stable(route_q) &&
       $stable(size_q) && $stable(vc_q)));

  a_r2_tail_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (type_q == FT_TAIL && vc_ready_i[vc_q]) |=> type_q == FT_IDLE);

  a_r2_head_then_payload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (type_q == FT_HEAD && vc_ready_i[vc_q]) |=> (type_q == FT_BODY || type_q == FT_TAIL));

  a_r9_take_loads_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_take_o |=> (data_q == $past(pay_data_i)));
endmodule

// File: rtl/tile_ni_pkt.sv
module tile_ni_pkt
  import tile_ni_pkg::*;
#(
  parameter int MY_X   = 0,
  parameter int MY_Y   = 0,
  parameter int NUM_VC = 8,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 4,
  localparam int VC_W  = $clog2(NUM_VC),
  localparam int HOPS  = 8,
  localparam int ROUTE_W = 2 * HOPS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [1:0]         req_dst_x_i,
  input  logic [1:0]         req_dst_y_i,
  input  logic [VC_W-1:0]    req_vc_i,
  input  logic [3:0]         req_size_i,
  input  logic [LEN_W-1:0]   req_len_i,
  input  logic [DATA_W-1:0]  pay_data_i,
  output logic               pay_take_o,
  output logic               err_o,
  input  logic [NUM_VC-1:0]  vc_ready_i,
  output logic [1:0]         flit_type_o,
  output logic [3:0]         flit_size_o,
  output logic [NUM_VC-1:0]  flit_vc_o,
  output logic [ROUTE_W-1:0] flit_route_o,
  output logic [DATA_W-1:0]  flit_data_o
);
  flit_type_e         cur_type;
  logic [ROUTE_W-1:0] new_route;
  logic [VC_W-1:0]    cur_vc;
  logic               accept, bad_req, start, err_q;

  assign req_ready_o = (cur_type == FT_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign bad_req     = (req_size_i > SIZE_MAX) || (req_len_i == '0);
  assign start       = accept && !bad_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= accept && bad_req;
  end
  assign err_o = err_q;

  ni_route_gen #(.MY_X(MY_X), .MY_Y(MY_Y), .HOPS(HOPS)) u_route (
    .dst_x_i (req_dst_x_i),
    .dst_y_i (req_dst_y_i),
    .route_o (new_route)
  );

  ni_flit_seq #(.NUM_VC(NUM_VC), .DATA_W(DATA_W), .LEN_W(LEN_W), .ROUTE_W(ROUTE_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .size_i     (req_size_i),
    .route_i    (new_route),
    .vc_i       (req_vc_i),
    .len_i      (req_len_i),
    .pay_data_i (pay_data_i),
    .vc_ready_i (vc_ready_i),
    .type_o     (cur_type),
    .size_o     (flit_size_o),
    .route_o    (flit_route_o),
    .vc_o       (cur_vc),
    .data_o     (flit_data_o),
    .pay_take_o (pay_take_o)
  );

  ni_vc_onehot #(.NUM_VC(NUM_VC)) u_vc (
    .en_i (cur_type != FT_IDLE),
    .vc_i (cur_vc),
    .oh_o (flit_vc_o)
  );

  assign flit_type_o = cur_type;

  a_r4_vc_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flit_type_o != 2'b00) |-> ($countones(flit_vc_o) == 1));

  a_r1_idle_fields_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flit_type_o == 2'b00) |-> (flit_vc_o == '0 && flit_route_o == '0 && flit_size_o == '0));

  a_r8_err_no_packet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (flit_type_o == 2'b00 && req_ready_o));

  a_r7_route_ends_extract: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flit_type_o == 2'b01) |-> (flit_route_o[ROUTE_W-1 -: 2] == HOP_EXTRACT));

  a_r10_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flit_type_o != 2'b00) |-> !req_ready_o);
endmodule

// File: tb/tile_ni_pkt_tb.sv
module tile_ni_pkt_tb;
  localparam int DW = 16;
  localparam int LW = 3;
  localparam int NV = 8;
  localparam int MX = 1;
  localparam int MY = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic          req_ready_o;
  logic [1:0]    req_dst_x_i = '0, req_dst_y_i = '0;
  logic [2:0]    req_vc_i = '0;
  logic [3:0]    req_size_i = '0;
  logic [LW-1:0] req_len_i = '0;
  logic [DW-1:0] pay_data_i;
  logic          pay_take_o, err_o;
  logic [NV-1:0] vc_ready_i = '0;
  logic [1:0]    flit_type_o;
  logic [3:0]    flit_size_o;
  logic [NV-1:0] flit_vc_o;
  logic [15:0]   flit_route_o;
  logic [DW-1:0] flit_data_o;

  int checks = 0;
  int errors = 0;
  int widx = 0;
  logic [7:0] pkt_tag = 8'h00;

  always #5 clk_i = ~clk_i;

  assign pay_data_i = {pkt_tag, 8'(widx)};
  always @(posedge clk_i) if (pay_take_o) widx <= widx + 1;

  tile_ni_pkt #(.MY_X(MX), .MY_Y(MY), .NUM_VC(NV), .DATA_W(DW), .LEN_W(LW)) u_dut (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_dst_x_i, .req_dst_y_i,
    .req_vc_i, .req_size_i, .req_len_i, .pay_data_i, .pay_take_o, .err_o,
    .vc_ready_i, .flit_type_o, .flit_size_o, .flit_vc_o, .flit_route_o, .flit_data_o
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ring_idx(input int node);
    int order[4] = '{0, 2, 3, 1};
    for (int i = 0; i < 4; i++) if (order[i] == node) return i;
    return 0;
  endfunction

  function automatic logic [15:0] exp_route(input int dx, input int dy);
    int sx, sy, nx, ny, n;
    bit negx, negy;
    logic [15:0] r;
    sx = (ring_idx(dx) - ring_idx(MX) + 4) % 4;
    sy = (ring_idx(dy) - ring_idx(MY) + 4) % 4;
    negx = (sx == 3); negy = (sy == 3);
    nx = negx ? 1 : sx; ny = negy ? 1 : sy;
    r = 16'hFFFF; n = 0;
    for (int k = 0; k < nx; k++) begin r[2*n +: 2] = 2'b00; n++; end
    for (int k = 0; k < ny; k++) begin
      r[2*n +: 2] = (k == 0 && nx > 0) ? ((negx == negy) ? 2'b01 : 2'b10) : 2'b00;
      n++;
    end
    return r;
  endfunction

  task automatic check_idle(input string tag);
    chk(flit_type_o == 2'b00, {tag, " R1 type"}, flit_type_o, 0);
    chk(flit_vc_o == '0 && flit_route_o == '0 && flit_size_o == '0 && flit_data_o == '0,
        {tag, " R1 fields"}, {flit_vc_o, flit_route_o, flit_size_o}, 0);
    chk(req_ready_o == 1'b1, {tag, " R10 ready"}, req_ready_o, 1);
  endtask

  task automatic send(input int dx, input int dy, input int vc, input int size,
                      input int len, input longint lit);
    bit bad;
    int f, base;
    logic [15:0] er;
    logic [1:0] et;
    logic [DW-1:0] ed;
    bit rdy;
    bad = (size > 8) || (len == 0);
    er  = exp_route(dx, dy);
    @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R10 ready before request", req_ready_o, 1);
    pkt_tag     = pkt_tag + 8'd1;
    req_valid_i = 1'b1;
    req_dst_x_i = 2'(dx); req_dst_y_i = 2'(dy);
    req_vc_i    = 3'(vc); req_size_i = 4'(size); req_len_i = LW'(len);
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    if (bad) begin
      chk(err_o == 1'b1, "R8 err pulse", err_o, 1);
      chk(flit_type_o == 2'b00, "R8 no flit", flit_type_o, 0);
      @(negedge clk_i);
      chk(err_o == 1'b0, "R8 err single cycle", err_o, 0);
      chk(flit_type_o == 2'b00, "R8 still idle", flit_type_o, 0);
      return;
    end
    chk(err_o == 1'b0, "R8 no err on good request", err_o, 0);
    base = widx;
    f = 0;
    while (f <= len) begin
      et = (f == 0) ? 2'b01 : ((f == len) ? 2'b11 : 2'b10);
      ed = (f == 0) ? '0 : {pkt_tag, 8'(base + f - 1)};
      chk(flit_type_o == et, "R2 type", flit_type_o, et);
      chk(flit_data_o == ed, "R2 data", flit_data_o, ed);
      chk(flit_vc_o == (NV'(1) << vc), "R4 vc onehot", flit_vc_o, NV'(1) << vc);
      chk(flit_size_o == 4'(size), "R5 size", flit_size_o, size);
      chk(flit_route_o == er, "R6 R7 route", flit_route_o, er);
      if (lit >= 0) chk(flit_route_o == 16'(lit), "R6 R7 directed route", flit_route_o, lit);
      chk(req_ready_o == 1'b0, "R10 busy", req_ready_o, 0);
      vc_ready_i = NV'($urandom);
      rdy = ($urandom % 5) < 3;
      vc_ready_i[vc] = rdy;
      #1;
      chk(pay_take_o == (rdy && f < len), "R9 take", pay_take_o, rdy && f < len);
      @(posedge clk_i);
      if (rdy) f++;
      @(negedge clk_i);
    end
    check_idle("after tail");
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    check_idle("reset");
    chk(err_o == 1'b0, "R8 err low at reset", err_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_idle("post reset");
    // R6 tie: ring distance two goes positive, two straight hops
    send(2, 2, 3, 5, 2, 64'hFFF0);
    // R7 negative row and column, same sign -> left turn
    send(3, 0, 0, 8, 1, 64'hFFF4);
    // R7 self destination -> extract only
    send(1, 2, 7, 0, 3, 64'hFFFF);
    // R2 single payload word, R5 largest size
    send(0, 3, 5, 8, 1, -1);
    // R8 rejects
    send(0, 0, 1, 9, 2, -1);
    send(0, 0, 1, 3, 0, -1);
    send(2, 1, 2, 15, 4, -1);
    for (int n = 0; n < 80; n++) begin
      int sz, ln;
      sz = ($urandom % 10 == 0) ? 9 + int'($urandom % 7) : int'($urandom % 9);
      ln = ($urandom % 12 == 0) ? 0 : 1 + int'($urandom % 7);
      send(int'($urandom % 4), int'($urandom % 4), int'($urandom % NV), sz, ln, -1);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule